// File: doc/BRIEF.md
# Cluster-Batched Interrupt Dispatch Sequencer

This block turns a request to interrupt a set of processors into a short run of writes to an interrupt command register. Processors are grouped sixteen to a cluster. For every cluster that contains at least one target, the block sends exactly one command write. That write names the cluster and carries a mask of the targeted members. A broadcast to N processors therefore costs one write per occupied cluster rather than one write per processor.

A request is made with a one-cycle start pulse. The pulse carries a processor bitmap, an interrupt vector and the requesting processor's own identifier. A flag asks the block to leave the requester out of the set, which gives "everyone but me" requests. Writes go out in ascending cluster order. Each write is held until the register path accepts it, and only then does the next one appear. Busy and done report the progress of the request.

The register path addresses the command register by a register index, not by a memory address. The block presents a fixed index taken from a parameter, which must lie in the range 0x800 to 0x8FF.

Top module: `ipi_cluster_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are all low.
- R2: Each command write has a 32-bit `cmd_dest`. Bits 31:16 hold the cluster number. Bit i of bits 15:0 is set exactly when processor 16*cluster+i is a target. Every cluster with at least one target gets exactly one write.
- R3: Writes are issued in ascending cluster number. A cluster with no targets gets no write.
- R4: While `cmd_valid` is high and `cmd_accept` is low, `cmd_valid`, `cmd_dest` and `cmd_vector` hold their values. The next write is presented only after the current one has been accepted.
- R5: When `excl_self` is 1 and `self_id` is below NUM_CPUS, processor `self_id` is removed from the set. When `excl_self` is 0, `self_id` has no effect.
- R6: If the set is empty after any exclusion, no write is issued, `busy` stays low, and `done` is high for one cycle, in the cycle after the start pulse.
- R7: `busy` goes high in the cycle after an accepted start. It falls at the same clock edge that accepts the final write. `done` is high for exactly that one following cycle.
- R8: A start pulse while `busy` is high is ignored: the writes of the request in progress are neither changed nor extended.
- R9: Every write carries the vector captured at start on `cmd_vector`, and the fixed register index parameter on `cmd_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse |
| dest_map | input | NUM_CPUS | Target processor bitmap, bit n = processor n |
| self_id | input | 32 | Identifier of the requesting processor |
| excl_self | input | 1 | Leave the requester out of the set |
| vector | input | VEC_W | Interrupt vector for this request |
| cmd_accept | input | 1 | Register path accepts the presented write |
| cmd_valid | output | 1 | A command write is presented |
| cmd_index | output | 12 | Register index of the command register |
| cmd_dest | output | 32 | Cluster number and member mask |
| cmd_vector | output | VEC_W | Vector of the presented write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a second start that arrives while a request is still waiting for an accept. If the register path is fast, the first request finishes before the second pulse lands, so the second one is never actually ignored. The bench therefore holds back accepts for several cycles and pulses start with a different bitmap during that stall. It then checks that the scoreboard sees only the first request's writes and that no write follows the done pulse. Removing the requester as the sole target is also covered, since that empty-after-exclusion request must finish without a single write.

// File: rtl/ipi_cluster_sequencer.sv
module ipi_cluster_sequencer #(
  parameter int          NUM_CPUS  = 64,
  parameter int          VEC_W     = 8,
  parameter logic [11:0] CMD_INDEX = 12'h830
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_CPUS-1:0] dest_map,
  input  logic [31:0]         self_id,
  input  logic                excl_self,
  input  logic [VEC_W-1:0]    vector,
  input  logic                cmd_accept,
  output logic                cmd_valid,
  output logic [11:0]         cmd_index,
  output logic [31:0]         cmd_dest,
  output logic [VEC_W-1:0]    cmd_vector,
  output logic                busy,
  output logic                done
);
  localparam int NCL  = (NUM_CPUS + 15) / 16;
  localparam int PADW = NCL * 16;
  localparam int CW   = (NCL > 1) ? $clog2(NCL) : 1;

  logic [PADW-1:0]  pend, pend_next, req_map;
  logic [CW-1:0]    sel;
  logic             found;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    req_map = '0;
    req_map[NUM_CPUS-1:0] = dest_map;
    for (int i = 0; i < NUM_CPUS; i++)
      if (excl_self && self_id == 32'(i)) req_map[i] = 1'b0;
  end

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = NCL - 1; i >= 0; i--)
      if (|pend[i*16 +: 16]) begin
        found = 1'b1;
        sel   = CW'(i);
      end
  end

  always_comb begin
    pend_next = pend;
    for (int i = 0; i < NCL; i++)
      if (CW'(i) == sel) pend_next[i*16 +: 16] = '0;
  end

  assign cmd_valid  = busy && found;
  assign cmd_index  = CMD_INDEX;
  assign cmd_dest   = {16'(sel), pend[sel*16 +: 16]};
  assign cmd_vector = vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      pend  <= '0;
      vec_q <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cmd_valid && cmd_accept) begin
          pend <= pend_next;
          if (pend_next == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else if (start) begin
        if (req_map != '0) begin
          busy  <= 1'b1;
          pend  <= req_map;
          vec_q <= vector;
        end else begin
          done <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_UNTIL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_accept |=> cmd_valid && $stable(cmd_dest) && $stable(cmd_vector)); // R4
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_dest[15:0] != 16'h0); // R2
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_accept |=> !cmd_valid || cmd_dest[31:16] > $past(cmd_dest[31:16])); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !cmd_valid); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(cmd_valid && cmd_accept) |=> $stable(cmd_dest)); // R8
endmodule

// File: tb/sim_ipi_cluster_sequencer.sv
module sim_ipi_cluster_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 0, rst_n = 0, start = 0, excl_self = 0, cmd_accept = 0;
  logic [N-1:0] dest_map = '0;
  logic [31:0]  self_id = '0;
  logic [7:0]   vector = '0;
  logic cmd_valid, busy, done;
  logic [11:0] cmd_index;
  logic [31:0] cmd_dest;
  logic [7:0]  cmd_vector;

  int checks = 0, errors = 0, writes_seen = 0, acc_delay = 0;
  logic [39:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cluster_sequencer #(.NUM_CPUS(N), .VEC_W(8), .CMD_INDEX(12'h830)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dest_map(dest_map), .self_id(self_id),
    .excl_self(excl_self), .vector(vector), .cmd_accept(cmd_accept), .cmd_valid(cmd_valid),
    .cmd_index(cmd_index), .cmd_dest(cmd_dest), .cmd_vector(cmd_vector), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and drives accept after acc_delay waits
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      cmd_accept = 0;
      if (rst_n && cmd_valid) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          writes_seen++;
          if (expq.size() == 0)
            check(0, "R3 unexpected write", {24'h0, cmd_vector, cmd_dest}, 0);
          else begin
            logic [39:0] e;
            e = expq.pop_front();
            check({cmd_vector, cmd_dest} == e, "R2/R3/R9 write content", {cmd_vector, cmd_dest}, e);
            check(cmd_index == 12'h830, "R9 index", cmd_index, 12'h830);
          end
          cmd_accept = 1;
          wait_cnt = acc_delay;
        end
      end
    end
  end

  // driver: computes expected writes and runs one request to completion
  task automatic run(input logic [N-1:0] m, input logic [31:0] sid, input bit ex,
                     input logic [7:0] v, input bit intrude);
    logic [N-1:0] eff;
    int cyc;
    eff = m;
    if (ex && sid < N) eff[sid] = 0;
    for (int c = 0; c < N/16; c++)
      if (eff[c*16 +: 16] != 0) expq.push_back({v, 16'(c), eff[c*16 +: 16]});
    dest_map = m; self_id = sid; excl_self = ex; vector = v; start = 1;
    @(negedge clk);
    start = 0;
    if (eff == 0) begin
      check(done && !busy, "R6 empty done next cycle", {busy, done}, 2'b01);
    end else begin
      check(busy, "R7 busy after start", busy, 1);
      if (intrude) begin
        dest_map = ~m; vector = ~v; start = 1;
        @(negedge clk);
        start = 0;
      end
      cyc = 0;
      while (!done && cyc < 500) begin
        check(busy, "R7 busy until final accept", busy, 1);
        @(negedge clk);
        cyc++;
      end
      check(done && !busy, "R7 done with busy low", {busy, done}, 2'b01);
    end
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
    check(expq.size() == 0, "R2 all writes issued", expq.size(), 0);
    repeat (4) begin
      @(negedge clk);
      check(!cmd_valid, "R8 no write after done", cmd_valid, 0);
    end
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !cmd_valid, "R1 reset state", {busy, done, cmd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    acc_delay = 0;
    run(64'h1, 0, 0, 8'h21, 0);                          // R2 single cpu
    run(64'hFFFF_FFFF_FFFF_FFFF, 5, 1, 8'h40, 0);        // R5 exclude self
    acc_delay = 2;
    run(64'h8000_0000_0001_0000, 3, 0, 8'h55, 0);        // R3 skip clusters 0 and 2, R4 stall
    run(64'h0000_0000_0000_0020, 5, 1, 8'h66, 0);        // R6 only self -> empty
    run(64'h0, 0, 0, 8'h67, 0);                          // R6 empty map
    run(64'h0000_0000_0000_0020, 5, 0, 8'h68, 0);        // R5 self kept
    run(64'h0000_0000_0000_0020, 70, 1, 8'h69, 0);       // R5 out-of-range self
    acc_delay = 4;
    run(64'h0001_0000_0000_0003, 0, 0, 8'h7A, 1);        // R8 intruding start
    acc_delay = 1;
    run(64'h5A5A_0000_A5A5_0F0F, 48, 1, 8'hC3, 0);       // R2 mixed masks
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule